// File: doc/BRIEF.md
# Cascadable Decimal Countdown Digit Chain

This block is the counting core of a decimal countdown timer. It keeps a row of decimal digits, four by default. Each digit is a 4-bit BCD value in its own register. Each slow timebase pulse, or each pulse a user injects by hand, arrives as a one-cycle `tick` enable in a single clock domain. On a tick the least significant digit goes down by one. A digit at zero borrows from the digits above it: it wraps to nine, and on the same edge it sends a one-cycle enable to the next digit up. It does this only when some higher digit is nonzero. When every digit is zero and nothing above the chain is nonzero, the count stops at zero.

Each digit is a ten-state machine with the states DIG0 to DIG9. No state exists for the codes 1010 to 1111, so the count can never pass through an invalid code. The digit has three transitions. TR_DEC moves from DIGk to DIG(k-1) on an enable. TR_WRAP moves from DIG0 to DIG9 on an enable while a higher digit is nonzero, and it pulses the borrow enable for the next digit. TR_HOLD keeps DIG0 on an enable while every higher digit is zero. Two further transitions set the state directly. TR_LOAD writes a clamped parallel value. TR_RESET forces DIG0 on a synchronous reset.

Several chains can be joined. Feed `hi_nz_in` from the `nz_out` of the chain above, and drive that chain's `tick` from this chain's `wrap_out`.

Top module: `bcdc_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, every digit becomes 0 on that edge (synchronous, active low). This takes priority over load and tick.
- R2: A tick without load lowers the least significant digit by one on the next edge when that digit is nonzero. For example, 2355 becomes 2354.
- R3: A digit at 0 wraps to 9 when it receives an enable and some higher digit is nonzero. The next higher digit is then lowered on the same edge: 2300 becomes 2299, and 1000 becomes 0999.
- R4: When every digit is 0 and `hi_nz_in` is low, a tick leaves the count at 0000 and `wrap_out` stays low.
- R5: When every digit is 0 and `hi_nz_in` is high, a tick makes the count 9999. During that tick cycle, `wrap_out` is high, combinationally, as the enable for the chain above.
- R6: Without tick and without load, the count holds its value.
- R7: When `load` is high, each digit takes its nibble of `load_val` on the next edge. Nibble i is bits 4i+3:4i, and nibble 0 is the least significant digit. Load takes priority over tick. A nibble above 9 loads as 9.
- R8: Every digit holds a value from 0 to 9 at all times after reset.
- R9: `nz_out` is high exactly when some digit is nonzero or `hi_nz_in` is high.
- R10: `wrap_out` is high only in a cycle with tick high and load low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle count-down enable |
| load | input | 1 | Parallel load strobe, priority over tick |
| load_val | input | 4*DIGITS | Load value, one BCD nibble per digit, clamped to 9 |
| hi_nz_in | input | 1 | High when a chain above holds a nonzero value |
| count | output | 4*DIGITS | Current BCD count, digit 0 in bits 3:0 |
| wrap_out | output | 1 | Borrow enable to the chain above (top digit wraps) |
| nz_out | output | 1 | High when this chain or anything above is nonzero |

## Verification
The hardest situation to reach is a borrow that ripples through several zero digits in one edge. An example is 1000 becoming 0999, where three wraps and one decrement must all happen on the same clock. A related case is the full wrap from 0000 to 9999 with `wrap_out` raised. Both states need several thousand ticks from a free-running count. The stimulus therefore uses the parallel load to place the chain directly at 2300, 1000 and 0000 and then applies a single tick. Out-of-range nibbles are loaded to exercise the clamp, and a load and a tick in the same cycle exercise the load priority.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

    localparam int DIG_W = 4;

    typedef enum logic [DIG_W-1:0] {
        DIG0 = 4'd0,
        DIG1 = 4'd1,
        DIG2 = 4'd2,
        DIG3 = 4'd3,
        DIG4 = 4'd4,
        DIG5 = 4'd5,
        DIG6 = 4'd6,
        DIG7 = 4'd7,
        DIG8 = 4'd8,
        DIG9 = 4'd9
    } digit_e;

    // Map any 4-bit code to a legal digit state; codes above nine become nine.
    function automatic digit_e to_digit(input logic [DIG_W-1:0] raw);
        if (raw > 4'd9) begin
            return DIG9;
        end
        return digit_e'(raw);
    endfunction

endpackage

// File: rtl/bcdc_load_clamp.sv
module bcdc_load_clamp
    import bcdc_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int VW = DIGITS * DIG_W
) (
    input  logic [VW-1:0] raw_val,
    output logic [VW-1:0] safe_val
);

    for (genvar g = 0; g < DIGITS; g++) begin : g_nib
        assign safe_val[g*DIG_W +: DIG_W] = to_digit(raw_val[g*DIG_W +: DIG_W]);
    end

endmodule

// File: rtl/bcdc_digit.sv
module bcdc_digit
    import bcdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,        // count-down enable from the digit below
    input  logic             above_nz,  // some higher digit is nonzero
    input  logic             load,
    input  logic [DIG_W-1:0] load_digit, // already clamped
    output logic [DIG_W-1:0] value,
    output logic             borrow,    // enable to the digit above
    output logic             nz         // this digit or any above is nonzero
);

    digit_e state_q;
    digit_e state_d;

    // Next-state selection: TR_LOAD, then TR_DEC / TR_WRAP / TR_HOLD.
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = to_digit(load_digit);
        end else if (en) begin
            unique case (state_q)
                DIG0:    state_d = above_nz ? DIG9 : DIG0;
                DIG1:    state_d = DIG0;
                DIG2:    state_d = DIG1;
                DIG3:    state_d = DIG2;
                DIG4:    state_d = DIG3;
                DIG5:    state_d = DIG4;
                DIG6:    state_d = DIG5;
                DIG7:    state_d = DIG6;
                DIG8:    state_d = DIG7;
                DIG9:    state_d = DIG8;
                default: state_d = DIG9;
            endcase
        end
    end

    // State register with TR_RESET.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIG0;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs derived from the present state.
    always_comb begin
        value  = state_q;
        nz     = above_nz;
        borrow = 1'b0;
        unique case (state_q)
            DIG0: begin
                borrow = en && !load && above_nz;
            end
            default: begin
                nz = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bcdc_counter.sv
module bcdc_counter
    import bcdc_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int VW = DIGITS * DIG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [VW-1:0] load_val,
    input  logic          hi_nz_in,
    output logic [VW-1:0] count,
    output logic          wrap_out,
    output logic          nz_out
);

    logic [VW-1:0]   safe_val;
    logic [DIGITS:0] en_chain;   // en_chain[i] enables digit i
    logic [DIGITS:0] nz_chain;   // nz_chain[i] : digit i or above nonzero
    logic            unused_nz;

    bcdc_load_clamp #(.DIGITS(DIGITS)) u_clamp (
        .raw_val  (load_val),
        .safe_val (safe_val)
    );

    assign en_chain[0]      = tick;
    assign nz_chain[DIGITS] = hi_nz_in;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        bcdc_digit u_dig (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (en_chain[g]),
            .above_nz   (nz_chain[g+1]),
            .load       (load),
            .load_digit (safe_val[g*DIG_W +: DIG_W]),
            .value      (count[g*DIG_W +: DIG_W]),
            .borrow     (en_chain[g+1]),
            .nz         (nz_chain[g])
        );
    end

    assign wrap_out  = en_chain[DIGITS];
    assign nz_out    = nz_chain[0];
    assign unused_nz = ^nz_chain[DIGITS:1];

endmodule

// File: rtl/bcdc_counter_chk.sv
module bcdc_counter_chk #(
    parameter int DIGITS = 4,
    localparam int VW = DIGITS * 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          load,
    input logic [VW-1:0] load_val,
    input logic          hi_nz_in,
    input logic [VW-1:0] count,
    input logic          wrap_out,
    input logic          nz_out
);

    localparam int TOP = (DIGITS - 1) * 4;

    // R1: reset clears every digit
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> count == '0);

    // R2: least significant digit decrements when nonzero
    a_r2_lsd_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && count[3:0] != 4'd0) |=> count[3:0] == $past(count[3:0]) - 4'd1);

    // R4: count stops at zero with nothing nonzero above
    a_r4_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0 && !hi_nz_in) |=> count == '0);

    // R5: a top wrap leaves nine in the top digit
    a_r5_top_wrap_nine: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_out |=> count[TOP +: 4] == 4'd9);

    // R6: nothing moves without tick or load
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(count));

    // R9: nz_out low implies an all-zero chain and nothing above
    a_r9_nz_low: assert property (@(posedge clk) disable iff (!rst_n)
        !nz_out |-> (count == '0 && !hi_nz_in));

    // R10: the borrow out needs a tick and no load
    a_r10_wrap_qual: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_out |-> (tick && !load));

    for (genvar g = 0; g < DIGITS; g++) begin : g_nib
        // R8: every digit stays in the decimal range
        a_r8_digit_valid: assert property (@(posedge clk) disable iff (!rst_n)
            count[g*4 +: 4] <= 4'd9);

        // R7: a legal nibble loads unchanged
        a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
            (load && load_val[g*4 +: 4] <= 4'd9) |=> count[g*4 +: 4] == $past(load_val[g*4 +: 4]));
    end

endmodule

bind bcdc_counter bcdc_counter_chk #(.DIGITS(DIGITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (load),
    .load_val (load_val),
    .hi_nz_in (hi_nz_in),
    .count    (count),
    .wrap_out (wrap_out),
    .nz_out   (nz_out)
);

// File: tb/sim_bcdc_counter.sv
module sim_bcdc_counter;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_val = '0;
    logic        hi_nz_in = 1'b0;
    logic [15:0] count;
    logic        wrap_out;
    logic        nz_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcdc_counter #(.DIGITS(4)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .hi_nz_in (hi_nz_in),
        .count    (count),
        .wrap_out (wrap_out),
        .nz_out   (nz_out)
    );

    typedef struct packed {
        logic        ld;
        logic [15:0] val;
        logic        tk;
        logic        hi;
        logic [15:0] exp_cnt;   // count after the edge
        logic        exp_wrap;  // wrap_out before the edge
    } vec_t;

    localparam vec_t VEC [N_VEC] = '{
        '{1'b1, 16'h2355, 1'b0, 1'b0, 16'h2355, 1'b0}, // R7 load
        '{1'b0, 16'h0000, 1'b1, 1'b0, 16'h2354, 1'b0}, // R2
        '{1'b1, 16'h2300, 1'b0, 1'b0, 16'h2300, 1'b0}, // R7
        '{1'b0, 16'h0000, 1'b1, 1'b0, 16'h2299, 1'b0}, // R3
        '{1'b1, 16'h1000, 1'b0, 1'b0, 16'h1000, 1'b0}, // R7
        '{1'b0, 16'h0000, 1'b1, 1'b0, 16'h0999, 1'b0}, // R3 deep borrow
        '{1'b1, 16'h0001, 1'b0, 1'b0, 16'h0001, 1'b0}, // R7
        '{1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0}, // R2
        '{1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0}, // R4 stop
        '{1'b0, 16'h0000, 1'b1, 1'b1, 16'h9999, 1'b1}, // R5 full wrap
        '{1'b0, 16'h0000, 1'b0, 1'b1, 16'h9999, 1'b0}, // R6 hold
        '{1'b1, 16'hFA0B, 1'b0, 1'b0, 16'h9909, 1'b0}, // R7 clamp
        '{1'b1, 16'h0005, 1'b1, 1'b1, 16'h0005, 1'b0}  // R7 priority, R10
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] to_bcd(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    function automatic logic valid_bcd(input logic [15:0] c);
        return c[3:0] <= 9 && c[7:4] <= 9 && c[11:8] <= 9 && c[15:12] <= 9;
    endfunction

    logic pre_wrap;
    logic pre_nz;

    // Drive on the falling edge, read comb outputs before the rising edge,
    // read the count just after the rising edge.
    task automatic step(input logic ld, input logic [15:0] v, input logic tk, input logic hi);
        @(negedge clk);
        load = ld; load_val = v; tick = tk; hi_nz_in = hi;
        #1;
        pre_wrap = wrap_out;
        pre_nz   = nz_out;
        @(posedge clk);
        #1;
        load = 1'b0; tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] prev;
        int model;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", count, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        prev = 16'h0000;
        for (int i = 0; i < N_VEC; i++) begin
            step(VEC[i].ld, VEC[i].val, VEC[i].tk, VEC[i].hi);
            check("R2/R3/R4/R5/R6/R7 count", count, VEC[i].exp_cnt);
            check("R5/R10 wrap_out", {15'd0, pre_wrap}, {15'd0, VEC[i].exp_wrap});
            check("R9 nz_out", {15'd0, pre_nz}, {15'd0, (prev != 0) || VEC[i].hi});
            check("R8 valid digits", {15'd0, valid_bcd(count)}, 16'd1);
            prev = VEC[i].exp_cnt;
        end

        // Long countdown through zero with nothing above: R2, R4
        step(1'b1, 16'h0012, 1'b0, 1'b0);
        model = 12;
        for (int k = 0; k < 15; k++) begin
            step(1'b0, 16'h0000, 1'b1, 1'b0);
            model = (model > 0) ? model - 1 : 0;
            check("R2/R4 countdown", count, to_bcd(model));
            check("R10 no wrap", {15'd0, pre_wrap}, 16'd0);
        end
        check("R9 nz low at zero", {15'd0, nz_out}, 16'd0);

        // Reset overrides load and tick: R1
        step(1'b1, 16'h4321, 1'b0, 1'b0);
        check("R7 load 4321", count, 16'h4321);
        @(negedge clk);
        rst_n = 1'b0; load = 1'b1; load_val = 16'h8888; tick = 1'b1;
        @(posedge clk);
        #1;
        check("R1 sync reset priority", count, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1; load = 1'b0; tick = 1'b0;

        // Ticks with hi_nz_in high from 0000 then step down: R5, R2
        step(1'b0, 16'h0000, 1'b1, 1'b1);
        check("R5 wrap from zero", count, 16'h9999);
        check("R5 wrap pulse", {15'd0, pre_wrap}, 16'd1);
        step(1'b0, 16'h0000, 1'b1, 1'b1);
        check("R2 after wrap", count, 16'h9998);
        check("R10 pulse single", {15'd0, pre_wrap}, 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule